// File: doc/BRIEF.md
# Partitioned Program/Erase Controller with Suspend

This block sequences embedded program and erase operations for a memory array divided into partitions and blocks. Software starts an operation by writing into a small command window that overlays the array address space: first the target address, then an opcode. The window position comes from a configuration input that a mode register drives. Each accepted operation is timed by its own down-counter. A program covers one word and takes `PROG_CYC` cycles. An erase covers one block and takes `ERASE_CYC` cycles.

While an operation runs, array reads to every other partition stay permitted. An erase can be paused so that reads and a single nested program can use any other block. A program can be paused so that reads can reach any word except the one being written. A paused operation keeps its remaining cycle count and continues from that count when resumed. Completion, suspension and error conditions appear in a six-bit status word. A read-permission output tells the array path whether each read may proceed.

Address layout: the partition is `addr[ADDR_W-1 -: PART_W]`, the block is `addr[ADDR_W-1:WORD_W]`, and the window is the four words whose address bits `[ADDR_W-1:2]` equal `ovl_base_i`.

Top module: `pe_ctrl`

## Requirements
- R1: After reset, `status_o` is 6'h01. The status bits are: bit0 ready (no operation counting), bit1 erase suspended, bit2 program suspended, bit3 program error, bit4 erase error, bit5 sequence error.
- R2: An operation accepted from idle drives ready low for exactly `PROG_CYC` cycles (program) or `ERASE_CYC` cycles (erase), counted from the accepting clock edge.
- R3: While an operation is counting, reads to its partition get `rd_ok_o`=0 and reads to other partitions get `rd_ok_o`=1.
- R4: Opcode 8'hB0 on a running erase sets bit1 and ready. During that suspension only reads to the erased block are refused, and a program to another block is accepted.
- R5: Opcode 8'hB0 on a running program (which takes priority over the erase) sets bit2. During that suspension only a read of the word being programmed is refused.
- R6: Opcode 8'hD0 resumes the suspended program if there is one. Otherwise it resumes the suspended erase, provided no program is active. The remaining count is frozen while suspended, so the operation finishes after the cycles it had left.
- R7: The request is rejected and bit5 is set in each of these cases: an erase while any operation is active; a program while a program is active; a program while an erase counts; a program into the suspended erase's block.
- R8: A program whose target word lies in the window sets bit3 and does not start. An erase whose target block contains the window sets bit4 and does not start.
- R9: Opcode 8'h50 clears bits 3, 4 and 5.
- R10: Only writes to window offset 1 (target, taken from `acc_wdata_i`) and offset 0 (opcode in `acc_wdata_i[7:0]`, 8'h40 program, 8'h20 erase) have effect. Writes outside the window are ignored, window reads get `rd_ok_o`=0, and moving `ovl_base_i` moves the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovl_base_i | input | ADDR_W-2 | Word-aligned window base (address bits ADDR_W-1:2) |
| acc_valid_i | input | 1 | Access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Access address |
| acc_wdata_i | input | ADDR_W | Write data: target address or opcode |
| rd_ok_o | output | 1 | Current read may proceed |
| status_o | output | 6 | Status word, see R1 |

## Verification
The hardest state to reach is a suspended erase that has a nested program running in another block. In that state two locks overlap: the erased block and the busy partition. The stimulus starts an erase and waits a known number of cycles before suspending it. It then starts a program in a different block of the same partition and fires conflicting requests at both targets. Finally it resumes the erase and counts cycles until ready, which shows that the count was frozen at the value left at the moment of suspension.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_PROG   = 8'h40;
  localparam logic [7:0] OP_CLR    = 8'h50;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_RESUME = 8'hD0;

  localparam int ST_RDY  = 0;
  localparam int ST_ESUS = 1;
  localparam int ST_PSUS = 2;
  localparam int ST_PERR = 3;
  localparam int ST_EERR = 4;
  localparam int ST_SERR = 5;
  localparam int ST_W    = 6;

  typedef struct packed {
    logic erase;
    logic prog;
    logic susp;
    logic resume;
    logic clr;
  } cmd_t;
endpackage

// File: rtl/pe_cmd_dec.sv
module pe_cmd_dec
  import pe_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-3:0] ovl_base_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [ADDR_W-1:0] acc_wdata_i,
  output logic              win_hit_o,
  output cmd_t              cmd_o,
  output logic [ADDR_W-1:0] tgt_o
);
  logic wr_cmd, wr_tgt;
  logic [7:0] op;

  assign win_hit_o = (acc_addr_i[ADDR_W-1:2] == ovl_base_i);
  assign wr_cmd    = acc_valid_i && acc_we_i && win_hit_o && (acc_addr_i[1:0] == 2'd0);
  assign wr_tgt    = acc_valid_i && acc_we_i && win_hit_o && (acc_addr_i[1:0] == 2'd1);
  assign op        = acc_wdata_i[7:0];

  always_comb begin
    cmd_o        = '0;
    cmd_o.erase  = wr_cmd && (op == OP_ERASE);
    cmd_o.prog   = wr_cmd && (op == OP_PROG);
    cmd_o.susp   = wr_cmd && (op == OP_SUSP);
    cmd_o.resume = wr_cmd && (op == OP_RESUME);
    cmd_o.clr    = wr_cmd && (op == OP_CLR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgt_o <= '0;
    else if (wr_tgt) tgt_o <= acc_wdata_i;
  end

  p_onecmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cmd_o) <= 1);
endmodule

// File: rtl/pe_op_slot.sv
module pe_op_slot #(
  parameter int TGT_W = 12,
  parameter int CYC   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic             susp_i,
  input  logic             resume_i,
  output logic             active_o,
  output logic             susp_o,
  output logic [TGT_W-1:0] tgt_o
);
  localparam int CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      susp_o   <= 1'b0;
      cnt_q    <= '0;
      tgt_o    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      susp_o   <= 1'b0;
      cnt_q    <= CNT_W'(CYC);
      tgt_o    <= tgt_i;
    end else if (active_o) begin
      if (susp_o) begin
        if (resume_i) susp_o <= 1'b0;
      end else if (susp_i) begin
        susp_o <= 1'b1;
      end else if (cnt_q == CNT_W'(1)) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && susp_o && !start_i) |=> $stable(cnt_q));
  p_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> ($past(cnt_q) == CNT_W'(1)));
  p_susp_act_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> active_o);
endmodule

// File: rtl/pe_access_chk.sv
module pe_access_chk #(
  parameter int ADDR_W = 12,
  parameter int PART_W = 2,
  parameter int WORD_W = 6
) (
  input  logic                     [ADDR_W-1:0] addr_i,
  input  logic                                  ers_run_i,
  input  logic                                  ers_sus_i,
  input  logic              [ADDR_W-WORD_W-1:0] ers_blk_i,
  input  logic                                  prg_run_i,
  input  logic                                  prg_sus_i,
  input  logic                     [ADDR_W-1:0] prg_tgt_i,
  output logic                                  ok_o
);
  logic [PART_W-1:0] a_part, e_part, p_part;
  logic [ADDR_W-WORD_W-1:0] a_blk;

  assign a_part = addr_i[ADDR_W-1 -: PART_W];
  assign a_blk  = addr_i[ADDR_W-1:WORD_W];
  assign e_part = ers_blk_i[ADDR_W-WORD_W-1 -: PART_W];
  assign p_part = prg_tgt_i[ADDR_W-1 -: PART_W];

  always_comb begin
    ok_o = 1'b1;
    if (ers_run_i && a_part == e_part)    ok_o = 1'b0;
    if (prg_run_i && a_part == p_part)    ok_o = 1'b0;
    if (ers_sus_i && a_blk == ers_blk_i)  ok_o = 1'b0;
    if (prg_sus_i && addr_i == prg_tgt_i) ok_o = 1'b0;
  end
endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PART_W    = 2,
  parameter int WORD_W    = 6,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-3:0] ovl_base_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [ADDR_W-1:0] acc_wdata_i,
  output logic              rd_ok_o,
  output logic [ST_W-1:0]   status_o
);
  localparam int BLK_W = ADDR_W - WORD_W;

  cmd_t              cmd;
  logic              win_hit, chk_ok;
  logic [ADDR_W-1:0] tgt;
  logic [BLK_W-1:0]  tgt_blk, ers_blk;
  logic [ADDR_W-1:0] prg_tgt;
  logic ers_act, ers_sus, prg_act, prg_sus, ers_run, prg_run;
  logic erase_ok, prog_ok, tgt_in_win, blk_has_win;
  logic ers_start, prg_start, ers_sreq, prg_sreq, ers_rreq, prg_rreq;
  logic perr_q, eerr_q, serr_q;

  pe_cmd_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .ovl_base_i, .acc_valid_i, .acc_we_i, .acc_addr_i,
    .acc_wdata_i, .win_hit_o(win_hit), .cmd_o(cmd), .tgt_o(tgt)
  );

  assign tgt_blk     = tgt[ADDR_W-1:WORD_W];
  assign tgt_in_win  = (tgt[ADDR_W-1:2] == ovl_base_i);
  assign blk_has_win = (tgt_blk == ovl_base_i[ADDR_W-3 -: BLK_W]);
  assign ers_run     = ers_act && !ers_sus;
  assign prg_run     = prg_act && !prg_sus;

  // one partition busy at a time; nested program only under a paused erase
  assign erase_ok  = cmd.erase && !ers_act && !prg_act;
  assign prog_ok   = cmd.prog && !prg_act && (!ers_act || (ers_sus && tgt_blk != ers_blk));
  assign ers_start = erase_ok && !blk_has_win;
  assign prg_start = prog_ok && !tgt_in_win;

  // suspend/resume target the program first
  assign prg_sreq = cmd.susp && prg_run;
  assign ers_sreq = cmd.susp && ers_run && !prg_act;
  assign prg_rreq = cmd.resume && prg_sus;
  assign ers_rreq = cmd.resume && ers_sus && !prg_act;

  pe_op_slot #(.TGT_W(BLK_W), .CYC(ERASE_CYC)) u_ers (
    .clk_i, .rst_ni, .start_i(ers_start), .tgt_i(tgt_blk), .susp_i(ers_sreq),
    .resume_i(ers_rreq), .active_o(ers_act), .susp_o(ers_sus), .tgt_o(ers_blk)
  );

  pe_op_slot #(.TGT_W(ADDR_W), .CYC(PROG_CYC)) u_prg (
    .clk_i, .rst_ni, .start_i(prg_start), .tgt_i(tgt), .susp_i(prg_sreq),
    .resume_i(prg_rreq), .active_o(prg_act), .susp_o(prg_sus), .tgt_o(prg_tgt)
  );

  pe_access_chk #(.ADDR_W(ADDR_W), .PART_W(PART_W), .WORD_W(WORD_W)) u_chk (
    .addr_i(acc_addr_i), .ers_run_i(ers_run), .ers_sus_i(ers_sus), .ers_blk_i(ers_blk),
    .prg_run_i(prg_run), .prg_sus_i(prg_sus), .prg_tgt_i(prg_tgt), .ok_o(chk_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      serr_q <= 1'b0;
    end else if (cmd.clr) begin
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (prog_ok && tgt_in_win)  perr_q <= 1'b1;
      if (erase_ok && blk_has_win) eerr_q <= 1'b1;
      if ((cmd.erase && !erase_ok) || (cmd.prog && !prog_ok)) serr_q <= 1'b1;
    end
  end

  assign status_o = {serr_q, eerr_q, perr_q, prg_sus, ers_sus, !(ers_run || prg_run)};
  assign rd_ok_o  = acc_valid_i && !acc_we_i && !win_hit && chk_ok;

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ers_run && prg_run));
  p_seq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.prog && prg_act) |=> status_o[ST_SERR]);
  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.clr |=> (status_o[ST_SERR:ST_PERR] == 3'b000));
  p_word_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_we_i && prg_sus && acc_addr_i == prg_tgt) |-> !rd_ok_o);
  p_blk_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && ers_sus && acc_addr_i[ADDR_W-1:WORD_W] == ers_blk) |-> !rd_ok_o);
endmodule

// File: tb/pe_ctrl_tb_top.sv
module pe_ctrl_tb_top;
  localparam int PC = 8;
  localparam int EC = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  ovl_base_i = 10'h3FC;  // window at 0xFF0..0xFF3
  logic        acc_valid_i = 1'b0;
  logic        acc_we_i = 1'b0;
  logic [11:0] acc_addr_i = '0;
  logic [11:0] acc_wdata_i = '0;
  logic        rd_ok_o;
  logic [5:0]  status_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  pe_ctrl #(.PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
    .clk_i, .rst_ni, .ovl_base_i, .acc_valid_i, .acc_we_i, .acc_addr_i,
    .acc_wdata_i, .rd_ok_o, .status_o
  );

  // {expected rd_ok, address} while erase of block 0x140 is suspended
  localparam logic [12:0] RD_TAB [8] = '{
    {1'b0, 12'h140}, {1'b0, 12'h17F}, {1'b1, 12'h180}, {1'b1, 12'h040},
    {1'b1, 12'h13F}, {1'b1, 12'h540}, {1'b0, 12'hFF0}, {1'b1, 12'hC00}
  };

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [11:0] d);
    acc_valid_i = 1'b1; acc_we_i = 1'b1; acc_addr_i = a; acc_wdata_i = d;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic exp, input string req);
    acc_valid_i = 1'b1; acc_we_i = 1'b0; acc_addr_i = a;
    #1;
    check(int'(rd_ok_o), int'(exp), req);
    acc_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!status_o[0] && n < 3000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(int'(status_o), 'h01, "R1 reset status");

    // R2 program timing
    wr(12'hFF1, 12'h801); wr(12'hFF0, 12'h040);
    wait_rdy(n);
    check(n, PC, "R2 program length");

    // R2/R3 erase timing and partition lock
    wr(12'hFF1, 12'h140); wr(12'hFF0, 12'h020);
    rd(12'h040, 1'b0, "R3 same partition");
    rd(12'h440, 1'b1, "R3 other partition");
    wait_rdy(n);
    check(n, EC - 2, "R2 erase length");

    // R10 writes outside window ignored, window reads refused
    wr(12'h123, 12'h040);
    check(int'(status_o), 'h01, "R10 outside write ignored");
    rd(12'hFF2, 1'b0, "R10 window read");

    // R4 erase suspend after 10 counted cycles
    wr(12'hFF1, 12'h140); wr(12'hFF0, 12'h020);
    repeat (10) @(negedge clk_i);
    wr(12'hFF0, 12'h0B0);
    check(int'(status_o), 'h03, "R4 erase suspended");
    for (int i = 0; i < 8; i++) rd(RD_TAB[i][11:0], RD_TAB[i][12], "R4 read table");

    // nested program in other block of same partition
    wr(12'hFF1, 12'h0C5); wr(12'hFF0, 12'h040);
    check(int'(status_o), 'h02, "R4 nested program accepted");
    rd(12'h0C5, 1'b0, "R3 nested partition busy");
    rd(12'h840, 1'b1, "R3 nested other partition");
    wr(12'hFF1, 12'h100); wr(12'hFF0, 12'h040);
    check(int'(status_o), 'h22, "R7 program while program active");
    wr(12'hFF0, 12'h050);
    check(int'(status_o), 'h02, "R9 clear");
    repeat (20) @(negedge clk_i);
    check(int'(status_o), 'h03, "R4 nested program done");
    wr(12'hFF1, 12'h150); wr(12'hFF0, 12'h040);
    check(int'(status_o), 'h23, "R7 program into suspended block");
    wr(12'hFF0, 12'h050);
    wr(12'hFF1, 12'h800); wr(12'hFF0, 12'h020);
    check(int'(status_o), 'h23, "R7 erase while erase suspended");
    wr(12'hFF0, 12'h050);
    check(int'(status_o), 'h03, "R9 clear");

    // R6 resume continues from frozen count
    wr(12'hFF0, 12'h0D0);
    wait_rdy(n);
    check(n, EC - 10, "R6 erase remaining");
    check(int'(status_o), 'h01, "R6 idle after erase");

    // R5 program suspend after 3 counted cycles
    wr(12'hFF1, 12'h801); wr(12'hFF0, 12'h040);
    repeat (3) @(negedge clk_i);
    wr(12'hFF0, 12'h0B0);
    check(int'(status_o), 'h05, "R5 program suspended");
    rd(12'h801, 1'b0, "R5 locked word");
    rd(12'h802, 1'b1, "R5 neighbour word");
    rd(12'h840, 1'b1, "R5 same partition");
    wr(12'hFF1, 12'h000); wr(12'hFF0, 12'h020);
    check(int'(status_o), 'h25, "R7 erase during program suspend");
    wr(12'hFF0, 12'h050);
    wr(12'hFF0, 12'h0D0);
    wait_rdy(n);
    check(n, PC - 3, "R6 program remaining");

    // R8 targets overlapping the window
    wr(12'hFF1, 12'hFF2); wr(12'hFF0, 12'h040);
    check(int'(status_o), 'h09, "R8 program error");
    wr(12'hFF1, 12'hFC0); wr(12'hFF0, 12'h020);
    check(int'(status_o), 'h19, "R8 erase error");
    wr(12'hFF0, 12'h050);
    check(int'(status_o), 'h01, "R9 clear errors");

    // R10 move window to 0x100
    ovl_base_i = 10'h040;
    wr(12'hFF1, 12'h900); wr(12'hFF0, 12'h020);
    check(int'(status_o), 'h01, "R10 old window dead");
    wr(12'h101, 12'h900); wr(12'h100, 12'h040);
    check(int'(status_o), 'h00, "R10 new window program");
    wr(12'h101, 12'h400); wr(12'h100, 12'h020);
    check(int'(status_o), 'h20, "R7 erase while program runs");
    wr(12'h100, 12'h050);
    wait_rdy(n);
    check(int'(status_o), 'h01, "R2 program done in new window");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule